// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block governs a low-power sleep state for a synchronous memory core. A sleep request arrives asynchronously to the system clock. The block samples it through a synchronizer chain and steps through four states: ACTIVE, ENTERING, ASLEEP and RECOVERING. Entry and exit each take a fixed latency. Only ASLEEP powers the core down, and only ACTIVE lets an access or a write through.

The memory's chip enables and both address-strobe inputs are watched continuously. The memory has to be deselected before sleep begins and has to stay deselected until recovery ends. Any strobe seen active while the controller is outside ACTIVE raises a sticky deselect-error flag. An access that is in flight when sleep starts is abandoned, and the block marks that moment with a one-cycle abort pulse. The stored contents are assumed to be retained, so the block only has to make sure no write reaches the core while it is away from ACTIVE.

Top module: `msc_sleep_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, the outputs are access_ok=1, in_sleep=0, core_pd=0, abort_acc=0 and deselect_err=0.
- R2: sleep_req_a passes through SYNC_STAGES (default 2) flops. With the default, a request that is high before rising edge k is first acted on at edge k+2, so in_sleep rises after edge k+2 and not earlier.
- R3: The ENTERING state lasts exactly ENTRY_CYCLES (default 2) cycles, with in_sleep=1 and core_pd=0. core_pd then rises and stays high while the synchronized request stays high.
- R4: Once the synchronized request is low in ASLEEP, core_pd falls at the next edge. RECOVERING then lasts exactly EXIT_CYCLES (default 2) cycles with in_sleep=1 and access_ok=0, after which access_ok returns to 1.
- R5: access_ok is 1 only in ACTIVE. wr_en equals wr_req AND access_ok, so no write is issued while in_sleep=1.
- R6: abort_acc is high for exactly the first cycle of ENTERING. This cancels any access caught in flight.
- R7: A chip enable is active when its pin equals its bit of CE_ACT_LEVEL (default 3'b010: ce_pin[1] is active high, ce_pin[0] and ce_pin[2] are active low). adsp_n and adsc_n are active low. If any of these is active in a cycle where in_sleep=1, deselect_err is 1 from the next edge onward and stays set until reset.
- R8: Strobes that are active while in ACTIVE do not set deselect_err.
- R9: If the request drops while in ENTERING, entry still completes to ASLEEP for one cycle and then the controller goes on to RECOVERING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_a | input | 1 | Asynchronous sleep request, active high |
| ce_pin | input | NUM_CE | Chip enable pins, polarity per CE_ACT_LEVEL |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| wr_req | input | 1 | Write request from the access path |
| in_sleep | output | 1 | High in any state other than ACTIVE |
| core_pd | output | 1 | Core power-down enable, high only in ASLEEP |
| access_ok | output | 1 | Access qualifier, high only in ACTIVE |
| wr_en | output | 1 | Qualified write enable to the core |
| abort_acc | output | 1 | One-cycle cancel of the in-flight access at sleep entry |
| deselect_err | output | 1 | Sticky flag for a strobe active outside ACTIVE |

## Verification
Directed sequences raise and drop the request in idle conditions. They count the exact edges at which in_sleep, core_pd and access_ok change, which separates a synchronizer or counter that is off by one from a correct one. Another directed case withdraws the request in the middle of entry and confirms that the full ENTERING, ASLEEP, RECOVERING path is taken. Random stimulus toggles the request with random hold times and drives mostly idle strobes with occasional active ones. A bench model predicts every output each cycle, so strobes in ACTIVE, which must stay harmless, are told apart from strobes during sleep or recovery, which must latch the error. Mid-run resets show that the error flag clears only on reset.

// File: rtl/msc_pkg.sv
package msc_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_ENTER   = 2'd1,
      ST_ASLEEP  = 2'd2,
      ST_RECOVER = 2'd3
   } msc_state_e;

   function automatic int unsigned msc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_a,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msc_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_a;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msc_strobe_dec.sv
module msc_strobe_dec #(
   parameter int unsigned       NUM_CE       = 3,
   parameter logic [NUM_CE-1:0] CE_ACT_LEVEL = 3'b010
) (
   input  logic [NUM_CE-1:0] ce_pin,
   input  logic              adsp_n,
   input  logic              adsc_n,
   output logic              strobe_any
);
   logic [NUM_CE-1:0] ce_act;

   generate
      if (NUM_CE < 1) begin : g_bad_ce
         $error("msc_strobe_dec: NUM_CE must be at least 1");
      end
      for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
         if (CE_ACT_LEVEL[i]) begin : g_hi
            assign ce_act[i] = ce_pin[i];
         end else begin : g_lo
            assign ce_act[i] = ~ce_pin[i];
         end
      end
   endgenerate

   assign strobe_any = (|ce_act) | ~adsp_n | ~adsc_n;
endmodule

// File: rtl/msc_fsm.sv
module msc_fsm
   import msc_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES = 2,
   parameter int unsigned EXIT_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   input  logic       strobe_any,
   output msc_state_e state_q,
   output logic       abort_q,
   output logic       err_q
);
   localparam int unsigned MAXC  = msc_max(ENTRY_CYCLES, EXIT_CYCLES);
   localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CNT_W-1:0] ENT_LOAD = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXT_LOAD = CNT_W'(EXIT_CYCLES - 1);

   generate
      if (ENTRY_CYCLES < 1 || EXIT_CYCLES < 1) begin : g_bad_lat
         $error("msc_fsm: latencies must be at least 1");
      end
   endgenerate

   msc_state_e       state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_ACTIVE: if (req_s) begin
            state_d = ST_ENTER;
            cnt_d   = ENT_LOAD;
         end
         ST_ENTER: begin
            if (cnt_q == '0) state_d = ST_ASLEEP;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_ASLEEP: if (!req_s) begin
            state_d = ST_RECOVER;
            cnt_d   = EXT_LOAD;
         end
         ST_RECOVER: begin
            if (cnt_q == '0) state_d = ST_ACTIVE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = ST_ACTIVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ACTIVE;
         cnt_q   <= '0;
         abort_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         abort_q <= (state_q == ST_ACTIVE) && req_s;
         err_q   <= err_q | ((state_q != ST_ACTIVE) && strobe_any);
      end
   end

   AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |=> !abort_q) else $error("abort pulse longer than one cycle"); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q) else $error("deselect error cleared without reset"); // R7
   AST_ERR_ACTIVE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && state_q == ST_ACTIVE) |=> !err_q) else $error("error set from ACTIVE"); // R8
endmodule

// File: rtl/msc_sleep_ctrl.sv
module msc_sleep_ctrl
   import msc_pkg::*;
#(
   parameter int unsigned       NUM_CE       = 3,
   parameter logic [NUM_CE-1:0] CE_ACT_LEVEL = 3'b010,
   parameter int unsigned       SYNC_STAGES  = 2,
   parameter int unsigned       ENTRY_CYCLES = 2,
   parameter int unsigned       EXIT_CYCLES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_req_a,
   input  logic [NUM_CE-1:0] ce_pin,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              wr_req,
   output logic              in_sleep,
   output logic              core_pd,
   output logic              access_ok,
   output logic              wr_en,
   output logic              abort_acc,
   output logic              deselect_err
);
   logic       req_s;
   logic       strobe_any;
   msc_state_e state_q;

   msc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_a(sleep_req_a), .q(req_s)
   );

   msc_strobe_dec #(.NUM_CE(NUM_CE), .CE_ACT_LEVEL(CE_ACT_LEVEL)) u_dec (
      .ce_pin(ce_pin), .adsp_n(adsp_n), .adsc_n(adsc_n), .strobe_any(strobe_any)
   );

   msc_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_s(req_s), .strobe_any(strobe_any),
      .state_q(state_q), .abort_q(abort_acc), .err_q(deselect_err)
   );

   assign access_ok = (state_q == ST_ACTIVE);
   assign in_sleep  = ~access_ok;
   assign core_pd   = (state_q == ST_ASLEEP);
   assign wr_en     = wr_req & access_ok;

   AST_NO_WR_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_sleep |-> !wr_en) else $error("write issued while sleeping"); // R5
   AST_OK_NOT_PD: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok |-> !core_pd) else $error("access allowed while powered down"); // R5
   AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pd) |-> ($past(in_sleep) && $past(in_sleep, 2) && !$past(core_pd, 2)))
      else $error("entry shorter than two cycles"); // R3
   AST_EXIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(access_ok) |-> (!$past(core_pd) && !$past(core_pd, 2) && $past(in_sleep, 2)))
      else $error("recovery shorter than two cycles"); // R4
endmodule

// File: tb/sim_msc_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_msc_sleep_ctrl;
   localparam logic [2:0] CE_LVL  = 3'b010;
   localparam logic [2:0] CE_IDLE = ~CE_LVL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req_a = 1'b0;
   logic [2:0] ce_pin = CE_IDLE;
   logic adsp_n = 1'b1, adsc_n = 1'b1, wr_req = 1'b0;
   logic in_sleep, core_pd, access_ok, wr_en, abort_acc, deselect_err;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   msc_sleep_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req_a(sleep_req_a), .ce_pin(ce_pin),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .wr_req(wr_req),
      .in_sleep(in_sleep), .core_pd(core_pd), .access_ok(access_ok),
      .wr_en(wr_en), .abort_acc(abort_acc), .deselect_err(deselect_err)
   );

   // reference model: 0 ACTIVE, 1 ENTERING, 2 ASLEEP, 3 RECOVERING
   logic [1:0] m_st;
   int         m_cnt;
   logic       m_s1, m_s2, m_abort, m_err;

   function automatic logic strobe_on(input logic [2:0] ce, input logic p, input logic c);
      return (|(ce ~^ CE_LVL)) | ~p | ~c;
   endfunction

   function automatic logic [1:0] next_st(input logic [1:0] st, input int cnt, input logic rq);
      case (st)
         2'd0: return rq ? 2'd1 : 2'd0;
         2'd1: return (cnt == 0) ? 2'd2 : 2'd1;
         2'd2: return rq ? 2'd2 : 2'd3;
         default: return (cnt == 0) ? 2'd0 : 2'd3;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 2'd0; m_cnt <= 0; m_s1 <= 1'b0; m_s2 <= 1'b0;
         m_abort <= 1'b0; m_err <= 1'b0;
      end else begin
         m_s1 <= sleep_req_a;
         m_s2 <= m_s1;
         m_st <= next_st(m_st, m_cnt, m_s2);
         if (m_st == 2'd0 && m_s2) m_cnt <= 1;
         else if (m_st == 2'd2 && !m_s2) m_cnt <= 1;
         else if ((m_st == 2'd1 || m_st == 2'd3) && m_cnt > 0) m_cnt <= m_cnt - 1;
         m_abort <= (m_st == 2'd0) && m_s2;
         m_err <= m_err | ((m_st != 2'd0) && strobe_on(ce_pin, adsp_n, adsc_n));
      end
   end

   task automatic chk(input logic act, input logic exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      chk(access_ok, m_st == 2'd0, "R5 access_ok vs model");
      chk(in_sleep, m_st != 2'd0, "R2 in_sleep vs model");
      chk(core_pd, m_st == 2'd2, "R3 core_pd vs model");
      chk(wr_en, wr_req & (m_st == 2'd0), "R5 wr_en vs model");
      chk(abort_acc, m_abort, "R6 abort_acc vs model");
      chk(deselect_err, m_err, "R7 deselect_err vs model");
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      cmp_model();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sleep_req_a = 1'b0;
      ce_pin = CE_IDLE; adsp_n = 1'b1; adsc_n = 1'b1; wr_req = 1'b0;
      #1;
      chk(access_ok, 1'b1, "R1 access_ok in reset");
      chk(deselect_err, 1'b0, "R1 err in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step();
      chk(in_sleep | core_pd | abort_acc | deselect_err, 1'b0, "R1 idle after reset");
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      // R2/R3/R6 directed entry timing
      wr_req = 1'b1;
      sleep_req_a = 1'b1;
      step(); chk(in_sleep, 1'b0, "R2 edge1 not asleep");
      step(); chk(in_sleep, 1'b0, "R2 edge2 not asleep");
      step(); chk(in_sleep, 1'b1, "R2 edge3 entering");
      chk(abort_acc, 1'b1, "R6 abort first entry cycle");
      chk(wr_en, 1'b0, "R5 write blocked");
      step(); chk(abort_acc, 1'b0, "R6 abort ends");
      chk(core_pd, 1'b0, "R3 still entering");
      step(); chk(core_pd, 1'b1, "R3 powered down");
      step(); chk(core_pd, 1'b1, "R3 stays down");
      // R4 directed exit timing
      sleep_req_a = 1'b0;
      step(); chk(core_pd, 1'b1, "R4 edge1 still down");
      step(); chk(core_pd, 1'b1, "R4 edge2 still down");
      step(); chk(core_pd, 1'b0, "R4 recovering");
      chk(access_ok, 1'b0, "R4 no access in recovery");
      step(); chk(access_ok, 1'b0, "R4 recovery second cycle");
      step(); chk(access_ok, 1'b1, "R4 back to active");
      chk(wr_en, 1'b1, "R5 write passes in active");
      chk(deselect_err, 1'b0, "R8 no error on clean cycle");
      // R8 strobes in ACTIVE are harmless
      adsp_n = 1'b0; ce_pin = CE_LVL;
      step(); step();
      chk(deselect_err, 1'b0, "R8 strobes in active");
      adsp_n = 1'b1; ce_pin = CE_IDLE;
      // R9 withdraw during ENTERING
      sleep_req_a = 1'b1;
      step(); step(); step();
      chk(in_sleep, 1'b1, "R9 entering");
      sleep_req_a = 1'b0;
      step(); step();
      chk(core_pd, 1'b1, "R9 entry completes");
      step();
      chk(core_pd, 1'b0, "R9 leaves sleep");
      step(); step();
      chk(access_ok, 1'b1, "R9 back to active");
      // R7 strobe during sleep latches error
      sleep_req_a = 1'b1;
      repeat (5) step();
      adsc_n = 1'b0;
      step();
      adsc_n = 1'b1;
      chk(deselect_err, 1'b1, "R7 error set");
      sleep_req_a = 1'b0;
      repeat (8) step();
      chk(deselect_err, 1'b1, "R7 error sticky");
      do_reset();
      chk(deselect_err, 1'b0, "R7 cleared by reset");
      // random phase
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 6) == 0) sleep_req_a = ~sleep_req_a;
         ce_pin = (($urandom % 10) == 0) ? 3'($urandom) : CE_IDLE;
         adsp_n = (($urandom % 12) != 0);
         adsc_n = (($urandom % 12) != 0);
         wr_req = 1'($urandom);
         step();
         if (($urandom % 400) == 0) do_reset();
      end
      finish_run();
   end
endmodule